// File: doc/BRIEF.md
# Scratchpad Buffered Page Write Engine

This block is a command engine placed between a bit-serial host stream and a 512-byte memory. The memory is organised as 16 pages of 32 bytes. Each host bit arrives least significant bit first with a one-cycle valid strobe. The block never writes host data straight into memory. Data goes first into a 32-byte staging buffer, and a pair of target-address bytes records where that data is to go. A read-only status byte records the last offset written and three flags: overflow, partial byte and authorization accepted.

The host starts each transaction with a frame reset and then sends a one-byte command. Three commands exist:

- **Fill** loads the target address and the staging data.
- **Dump** returns the address bytes, the status byte and the staged data, so the host can check them.
- **Commit** moves the staged bytes into memory. It runs only after the host echoes the two address bytes and the status byte exactly.

While the commit runs, the response line signals busy. When the commit ends, the line signals completion.

Top module: `spad_copy_engine`

## Requirements
- R1: Command bytes are taken LSB first: 0x0F selects fill, 0xAA selects dump, 0x55 selects commit. Any other code makes the block ignore all bits and hold `bit_out` at 1 until the next frame reset.
- R2: Fill takes the low address byte, then the high address byte, then data bits. Data is stored starting at the offset held in address bits 4:0. Status bits 4:0 then hold the offset of the last byte touched, or the start offset when no data bit was sent.
- R3: Data bits aimed past offset 31 are dropped, and status bit 6 (overflow) is set.
- R4: When a fill frame ends in the middle of a byte and no overflow occurred, status bit 5 (partial) is set. The received bits land in the low positions of that byte, and its upper bits keep their previous value.
- R5: A fill command clears status bits 7, 6 and 5.
- R6: Dump returns the low address byte, the high address byte, the status byte, and then staged data from the start offset. Every byte read past offset 31 is 0xFF. Dump changes no state.
- R7: A commit whose three echo bytes equal low address, high address and status, in that order, sets status bit 7. It then writes staged bytes from the start offset through the last offset into memory at address {high[0], low[7:5], offset}.
- R8: During a commit, `bit_out` is 1 for exactly one clock per byte copied and `mem_we` pulses once per byte. After that, `bit_out` is 0 until the next frame reset.
- R9: A frame reset that arrives while a commit is running has no effect on the copy.
- R10: When an echo byte mismatches, no memory write occurs, the status stays unchanged, and `bit_out` stays 1 until the next frame reset.
- R11: Status bit 7 survives dump commands and failed commits. Only a fill command clears it.
- R12: After `rst_n`, both address bytes and the status byte read 0, `bit_out` is 1 and `mem_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_rst | input | 1 | One-cycle frame reset that aborts the current command |
| bit_vld | input | 1 | Marks a host bit slot in this cycle |
| bit_in | input | 1 | Host data bit, LSB first |
| bit_out | output | 1 | Response bit for the current slot; busy/done indication during a commit |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | 9 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |

## Verification
Fill lengths are drawn at random so that the tests cover clean whole-byte ends, ends in the middle of a byte, and runs past the page end. This separates the partial flag from the overflow flag and tests the ending-offset rule at both the start offset and at offset 31. Start offsets and page numbers are random. A dump after every fill shows whether data landed at the right offsets and whether reads past the end return 0xFF. Echo bytes are either exact or carry one flipped bit, which separates a real commit from a rejected one through the count of write strobes, the busy length and the memory image. Directed cases cover a fill with no data, a frame reset during a commit, and an unknown command.

// File: rtl/spad_pkg.sv
package spad_pkg;
  typedef enum logic [2:0] {
    ST_CMD, ST_WADDR, ST_WDATA, ST_RDOUT, ST_AUTH, ST_COPY, ST_DONE, ST_IGNORE
  } spad_state_e;

  localparam logic [7:0] OP_FILL   = 8'h0F;
  localparam logic [7:0] OP_DUMP   = 8'hAA;
  localparam logic [7:0] OP_COMMIT = 8'h55;
endpackage

// File: rtl/spad_bitrx.sv
module spad_bitrx #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              bit_vld,
  input  logic              bit_in,
  output logic [CNT_W-1:0]  cnt,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val
);
  logic [BYTE_W-2:0] sh;
  logic [BYTE_W-2:0] sh_n;
  logic [CNT_W-1:0]  cnt_n;

  assign byte_done = bit_vld && (cnt == CNT_W'(BYTE_W-1));
  assign byte_val  = {bit_in, sh};

  always_comb begin
    sh_n  = sh;
    cnt_n = cnt;
    if (clr) begin
      cnt_n = '0;
    end else if (bit_vld) begin
      sh_n  = {bit_in, sh[BYTE_W-2:1]};
      cnt_n = CNT_W'(cnt + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else begin
      sh  <= sh_n;
      cnt <= cnt_n;
    end
  end
endmodule

// File: rtl/spad_array.sv
module spad_array #(
  parameter int DEPTH  = 32,
  parameter int BYTE_W = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int BIT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BIT_W-1:0]  wr_bit,
  input  logic              wr_val,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BYTE_W-1:0] rd_data
);
  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx][wr_bit] <= wr_val;
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/spad_copy_engine.sv
module spad_copy_engine
  import spad_pkg::*;
#(
  parameter int PAGE_BYTES = 32,
  parameter int NUM_PAGES  = 16,
  localparam int BYTE_W = 8,
  localparam int CNT_W  = $clog2(BYTE_W),
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int PG_W   = $clog2(NUM_PAGES),
  localparam int ADDR_W = OFF_W + PG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_rst,
  input  logic              bit_vld,
  input  logic              bit_in,
  output logic              bit_out,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata
);
  spad_state_e state, state_n;
  logic [1:0]        bcnt, bcnt_n;
  logic [OFF_W:0]    off, off_n;
  logic [OFF_W-1:0]  cpy_off, cpy_off_n;
  logic [7:0]        ta1, ta1_n, ta2, ta2_n;
  logic [OFF_W-1:0]  es_end, es_end_n;
  logic              es_of, es_of_n, es_pf, es_pf_n, es_aa, es_aa_n;

  logic [CNT_W-1:0]  rx_cnt;
  logic              byte_done;
  logic [BYTE_W-1:0] byte_val;
  logic              fr_take;
  logic              spad_we;
  logic [OFF_W-1:0]  rd_idx;
  logic [BYTE_W-1:0] rd_data;
  logic [7:0]        es_byte;
  logic [7:0]        auth_ref;
  logic [7:0]        out_byte;
  logic [OFF_W-1:0]  start_off;
  logic [ADDR_W-1:0] tgt;

  assign fr_take   = frame_rst && (state != ST_COPY);
  assign es_byte   = {es_aa, es_of, es_pf, 5'(es_end)};
  assign start_off = ta1[OFF_W-1:0];
  assign tgt       = ADDR_W'({ta2, ta1});

  spad_bitrx #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(fr_take), .bit_vld(bit_vld), .bit_in(bit_in),
    .cnt(rx_cnt), .byte_done(byte_done), .byte_val(byte_val)
  );

  spad_array #(.DEPTH(PAGE_BYTES), .BYTE_W(BYTE_W)) u_spad (
    .clk(clk), .wr_en(spad_we), .wr_idx(off[OFF_W-1:0]), .wr_bit(rx_cnt),
    .wr_val(bit_in), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  always_comb begin
    case (bcnt)
      2'd0:    auth_ref = ta1;
      2'd1:    auth_ref = ta2;
      default: auth_ref = es_byte;
    endcase
  end

  // next-state process
  always_comb begin
    state_n = state;  bcnt_n = bcnt;  off_n = off;  cpy_off_n = cpy_off;
    ta1_n = ta1;  ta2_n = ta2;  es_end_n = es_end;
    es_of_n = es_of;  es_pf_n = es_pf;  es_aa_n = es_aa;
    spad_we = 1'b0;
    if (fr_take) begin
      if (state == ST_WDATA && rx_cnt != '0 && !es_of) es_pf_n = 1'b1;
      state_n = ST_CMD;
      bcnt_n  = '0;
    end else begin
      case (state)
        ST_CMD: if (byte_done) begin
          bcnt_n = '0;
          case (byte_val)
            OP_FILL: begin
              state_n = ST_WADDR;
              es_aa_n = 1'b0; es_of_n = 1'b0; es_pf_n = 1'b0;
            end
            OP_DUMP:   state_n = ST_RDOUT;
            OP_COMMIT: state_n = ST_AUTH;
            default:   state_n = ST_IGNORE;
          endcase
        end
        ST_WADDR: if (byte_done) begin
          if (bcnt == 2'd0) begin
            ta1_n  = byte_val;
            bcnt_n = 2'd1;
          end else begin
            ta2_n    = byte_val;
            off_n    = {1'b0, start_off};
            es_end_n = start_off;
            state_n  = ST_WDATA;
          end
        end
        ST_WDATA: if (bit_vld) begin
          if (off[OFF_W]) begin
            es_of_n = 1'b1;
          end else begin
            spad_we  = 1'b1;
            es_end_n = off[OFF_W-1:0];
            if (rx_cnt == CNT_W'(BYTE_W-1)) off_n = (OFF_W+1)'(off + 1'b1);
          end
        end
        ST_RDOUT: if (byte_done) begin
          if (bcnt != 2'd3) bcnt_n = 2'(bcnt + 1'b1);
          if (bcnt == 2'd2) off_n = {1'b0, start_off};
          if (bcnt == 2'd3 && !off[OFF_W]) off_n = (OFF_W+1)'(off + 1'b1);
        end
        ST_AUTH: if (byte_done) begin
          if (byte_val != auth_ref) begin
            state_n = ST_IGNORE;
          end else if (bcnt == 2'd2) begin
            es_aa_n   = 1'b1;
            cpy_off_n = start_off;
            state_n   = ST_COPY;
          end else begin
            bcnt_n = 2'(bcnt + 1'b1);
          end
        end
        ST_COPY: begin
          if (cpy_off == es_end) state_n = ST_DONE;
          else cpy_off_n = OFF_W'(cpy_off + 1'b1);
        end
        default: ;
      endcase
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_CMD;  bcnt <= '0;  off <= '0;  cpy_off <= '0;
      ta1 <= '0;  ta2 <= '0;  es_end <= '0;
      es_of <= 1'b0;  es_pf <= 1'b0;  es_aa <= 1'b0;
    end else begin
      state <= state_n;  bcnt <= bcnt_n;  off <= off_n;  cpy_off <= cpy_off_n;
      ta1 <= ta1_n;  ta2 <= ta2_n;  es_end <= es_end_n;
      es_of <= es_of_n;  es_pf <= es_pf_n;  es_aa <= es_aa_n;
    end
  end

  // outputs
  assign rd_idx    = (state == ST_COPY) ? cpy_off : off[OFF_W-1:0];
  assign mem_we    = (state == ST_COPY);
  assign mem_addr  = {tgt[ADDR_W-1:OFF_W], cpy_off};
  assign mem_wdata = rd_data;

  always_comb begin
    case (bcnt)
      2'd0:    out_byte = ta1;
      2'd1:    out_byte = ta2;
      2'd2:    out_byte = es_byte;
      default: out_byte = off[OFF_W] ? '1 : rd_data;
    endcase
    case (state)
      ST_RDOUT: bit_out = out_byte[rx_cnt];
      ST_DONE:  bit_out = 1'b0;
      default:  bit_out = 1'b1;
    endcase
  end

  // assertions
  a_r8_we_shows_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> bit_out);
  a_r3_ovf_at_last_offset: assert property (@(posedge clk) disable iff (!rst_n)
    es_of |-> (es_end == '1));
  a_r4_pf_excludes_of: assert property (@(posedge clk) disable iff (!rst_n)
    !(es_pf && es_of));
  a_r7_aa_after_echo: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(es_aa) |-> $past(state == ST_AUTH));
  a_r7_copy_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[OFF_W-1:0] >= start_off && mem_addr[OFF_W-1:0] <= es_end));
  a_r9_copy_ignores_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COPY && frame_rst) |=> (state == ST_COPY || state == ST_DONE));
  a_r5_fill_clears_aa: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WADDR) |-> !es_aa);
endmodule

// File: tb/spad_copy_engine_bench.sv
`timescale 1ns/1ps
module spad_copy_engine_bench;
  logic clk = 1'b0;
  logic rst_n, frame_rst, bit_vld, bit_in;
  logic bit_out, mem_we;
  logic [8:0] mem_addr;
  logic [7:0] mem_wdata;

  always #4 clk = ~clk;

  spad_copy_engine u_spad_copy_engine (
    .clk(clk), .rst_n(rst_n), .frame_rst(frame_rst), .bit_vld(bit_vld), .bit_in(bit_in),
    .bit_out(bit_out), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  int n_tests = 0, n_fail = 0, we_cnt = 0;
  logic [7:0] obs_mem [512];
  logic [7:0] exp_mem [512];
  logic [7:0] m_sp [32];
  logic [7:0] m_ta1, m_ta2;
  int m_end;
  logic m_of, m_pf, m_aa;

  always @(posedge clk) if (mem_we) begin
    obs_mem[mem_addr] <= mem_wdata;
    we_cnt <= we_cnt + 1;
  end

  function automatic logic [7:0] m_es();
    return {m_aa, m_of, m_pf, 5'(m_end)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, output logic so);
    @(negedge clk); bit_vld = 1'b1; bit_in = b; #1 so = bit_out;
  endtask

  task automatic send_byte(input logic [7:0] v);
    logic d;
    for (int i = 0; i < 8; i++) send_bit(v[i], d);
  endtask

  task automatic recv_byte(output logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(1'b1, v[i]);
  endtask

  task automatic frame();
    @(negedge clk); bit_vld = 1'b0; frame_rst = 1'b1;
    @(negedge clk); frame_rst = 1'b0;
  endtask

  task automatic do_fill(input logic [7:0] t1, input logic [7:0] t2, input int nbits);
    logic d, b;
    int o;
    frame();
    send_byte(8'h0F);
    m_aa = 0; m_of = 0; m_pf = 0;
    send_byte(t1); send_byte(t2);
    m_ta1 = t1; m_ta2 = t2; m_end = t1[4:0];
    for (int i = 0; i < nbits; i++) begin
      b = 1'($urandom);
      o = t1[4:0] + i / 8;
      if (o < 32) begin m_sp[o][i % 8] = b; m_end = o; end
      else m_of = 1;
      send_bit(b, d);
    end
    frame();
    if ((nbits % 8) != 0 && !m_of) m_pf = 1;
  endtask

  task automatic check_dump(input string tag);
    logic [7:0] v;
    frame();
    send_byte(8'hAA);
    recv_byte(v); chk({tag, " R6 low addr"}, v, m_ta1);
    recv_byte(v); chk({tag, " R6 high addr"}, v, m_ta2);
    recv_byte(v); chk({tag, " R2/R3/R4 status"}, v, m_es());
    for (int o = m_ta1[4:0]; o < 34; o++) begin
      recv_byte(v);
      chk({tag, " R6 data"}, v, (o < 32) ? m_sp[o] : 8'hFF);
    end
  endtask

  task automatic do_commit(input logic bad, input logic mid_rst, input string tag);
    logic [7:0] a [3];
    int busy, we0, n, k, bad_cnt;
    logic [8:0] ad;
    frame();
    we0 = we_cnt;
    a[0] = m_ta1; a[1] = m_ta2; a[2] = m_es();
    if (bad) begin
      k = $urandom_range(0, 2);
      a[k] = a[k] ^ (8'h01 << $urandom_range(0, 7));
    end
    send_byte(8'h55);
    for (int i = 0; i < 3; i++) send_byte(a[i]);
    busy = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk); bit_vld = 1'b0; frame_rst = mid_rst && (c == 0); #1;
      if (bit_out) busy++; else break;
    end
    frame_rst = 1'b0;
    if (bad) begin
      chk({tag, " R10 no write"}, we_cnt - we0, 0);
      chk({tag, " R10 line held high"}, busy, 40);
    end else begin
      n = m_end - m_ta1[4:0] + 1;
      chk({tag, mid_rst ? " R9 busy length" : " R8 busy length"}, busy, n);
      chk({tag, " R8 write count"}, we_cnt - we0, n);
      m_aa = 1;
      for (int o = m_ta1[4:0]; o <= m_end; o++) begin
        ad = {m_ta2[0], m_ta1[7:5], 5'(o)};
        exp_mem[ad] = m_sp[o];
      end
      bad_cnt = 0;
      for (int i = 0; i < 512; i++) if (obs_mem[i] !== exp_mem[i]) bad_cnt++;
      chk({tag, " R7 memory image"}, bad_cnt, 0);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    for (int i = 0; i < 512; i++) begin obs_mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    rst_n = 1'b0; frame_rst = 1'b0; bit_vld = 1'b0; bit_in = 1'b0;
    m_ta1 = 0; m_ta2 = 0; m_end = 0; m_of = 0; m_pf = 0; m_aa = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R12 bit_out after reset", bit_out, 1);
    chk("R12 mem_we after reset", mem_we, 0);
    rst_n = 1'b1;
    frame(); send_byte(8'hAA);
    recv_byte(v); chk("R12 low addr", v, 0);
    recv_byte(v); chk("R12 high addr", v, 0);
    recv_byte(v); chk("R12 status", v, 0);
    // unknown command: all later bits ignored, line stays high
    frame(); send_byte(8'h3C);
    recv_byte(v); chk("R1 unknown command ignored", v, 8'hFF);
    // full page, whole bytes
    do_fill(8'h20, 8'h00, 256); check_dump("full");
    chk("R3 no overflow at exact page", m_es() & 8'h60, 0);
    do_commit(0, 0, "full");
    chk("R11 aa after commit", m_es() >> 7, 1);
    check_dump("aa kept by dump");
    do_commit(1, 0, "bad echo");
    check_dump("R11 aa kept by failed commit");
    // overflow
    do_fill(8'hDC, 8'h01, 43); check_dump("overflow");
    chk("R5 fill cleared aa", m_aa, 0);
    do_commit(0, 0, "overflow");
    // partial
    do_fill(8'h45, 8'h00, 19); check_dump("partial");
    do_commit(0, 1, "partial with mid reset");
    // no data
    do_fill(8'h8A, 8'h01, 0); check_dump("empty");
    do_commit(0, 0, "empty");
    for (int it = 0; it < 20; it++) begin
      do_fill(8'($urandom), 8'($urandom), $urandom_range(0, 300));
      check_dump("random");
      do_commit(($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0), "random");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule